// File: doc/BRIEF.md
# Two-Cluster Snooping Coherency Controller

This block keeps two processor clusters, each with a private cache, coherent with respect to one shared memory port. It keeps a small tag/state table with one entry per line for each cluster. Each entry holds one of five states. A state is Invalid, or it is a valid state made from two choices: unique or shared ownership, and clean or dirty data. Clusters send read, make-unique and store requests. The controller answers each request with a granted line state, and on a fill it also returns the line data.

A read that misses locally first snoops the other cluster. If that cluster holds the line, it supplies the data and both copies end up shared. If it does not, the line is fetched from memory and granted unique. A make-unique request on a shared copy sends an invalidate to the other cluster. The grant is given only after that cluster acknowledges. Stores are allowed only on unique lines, and they leave the line dirty. One transaction is in flight at a time. When both clusters request in the same cycle, a fixed-priority arbiter chooses between them. A debug port exposes the whole state table.

Top module: `coh_ctrl`

## Requirements
- R1: After reset every line in both clusters is Invalid. The state encoding is Invalid=0, UniqueClean=1, SharedClean=2, UniqueDirty=3, SharedDirty=4, and it appears on the debug port as `dbg_state_o[cluster][line]`. No response, snoop or memory request is active after reset.
- R2: A read (opcode 0) from a cluster that does not hold the line sends exactly one snoop to the other cluster. The snoop carries the line address and has `snp_inv_o`=0.
- R3: When that snoop reports a miss, one memory read is issued for the address. The requester is then granted UniqueClean together with the memory data, one cycle after the memory data arrives.
- R4: When that snoop reports a hit, the requester is granted SharedClean with the data from the snooped cluster. The snooped copy moves UniqueClean→SharedClean or UniqueDirty→SharedDirty; a copy that is already shared keeps its state.
- R5: A make-unique (opcode 1) on a shared copy sends an invalidate snoop (`snp_inv_o`=1) to the other cluster. The grant comes only after the acknowledge. At the grant the other copy is Invalid, and the requester holds UniqueDirty if either copy was dirty, otherwise UniqueClean.
- R6: A make-unique on a line already held unique is granted at once, with the state unchanged and no snoop. A make-unique on an Invalid line is rejected (`rsp_ok_o`=0), with no snoop and the state unchanged.
- R7: A store (opcode 2) on a unique line is accepted and leaves the line UniqueDirty. A store on a line that is not unique is rejected, with no snoop and the state unchanged.
- R8: A read from a cluster that already holds a valid copy is answered in the next cycle with its current state. It causes no snoop and no memory read.
- R9: When both clusters request in the same cycle, cluster 0 is accepted. The other cluster's `req_ready_o` stays low until the in-flight transaction has responded.
- R10: The controller waits for snoop responses of any latency; responses of 6, 13 and 16 cycles are exercised. A read that hits is answered one cycle after the snoop response.
- R11: No line is ever unique in one cluster while it is valid in the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 2 | Request valid, one bit per cluster |
| req_op_i | input | 2x2 | Request opcode per cluster: 0 read, 1 make-unique, 2 store |
| req_addr_i | input | 2xAW | Request line address per cluster |
| req_ready_o | output | 2 | Request accepted this cycle, one bit per cluster |
| rsp_valid_o | output | 2 | One-cycle response pulse per cluster |
| rsp_ok_o | output | 1 | 1 = granted, 0 = rejected |
| rsp_state_o | output | 3 | Line state granted to (or kept by) the requester |
| rsp_data_o | output | DW | Line data on fills from a snoop or from memory |
| snp_valid_o | output | 2 | One-cycle snoop pulse per cluster |
| snp_inv_o | output | 1 | 1 = invalidate snoop, 0 = read snoop |
| snp_addr_o | output | AW | Snooped line address |
| snp_rsp_valid_i | input | 2 | Snoop response or acknowledge per cluster |
| snp_rsp_hit_i | input | 2 | Snoop response hit flag per cluster |
| snp_rsp_data_i | input | 2xDW | Line data supplied on a snoop hit |
| mem_req_o | output | 1 | One-cycle memory read pulse |
| mem_addr_o | output | AW | Memory read line address |
| mem_rsp_valid_i | input | 1 | Memory data valid |
| mem_rsp_data_i | input | DW | Memory line data |
| dbg_state_o | output | 2x2^AW x3 | State table for both clusters |

## Verification
A corrupt table entry becomes visible on the debug port in the cycle right after the faulty update, and the bench compares the whole table after every scenario. A wrong state machine transition shows up one of three ways: the granted state is wrong, a snoop or memory pulse is missing or extra, or the response arrives at the wrong time. Each response is timed against the exact cycle count expected from the snoop and memory latencies, so a grant given too early is caught, for example a make-unique answered before its acknowledge. A broken exclusivity rule is flagged on the first clock edge at which a unique copy coexists with another valid copy.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [2:0] {
    LS_INV = 3'd0,
    LS_UC  = 3'd1,
    LS_SC  = 3'd2,
    LS_UD  = 3'd3,
    LS_SD  = 3'd4
  } lstate_e;

  typedef enum logic [1:0] {
    OP_RD   = 2'd0,
    OP_MU   = 2'd1,
    OP_ST   = 2'd2,
    OP_NONE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    EG_IDLE = 2'd0,
    EG_SNP  = 2'd1,
    EG_MEM  = 2'd2
  } eng_e;

  function automatic logic ls_valid(lstate_e s);
    return s != LS_INV;
  endfunction

  function automatic logic ls_uniq(lstate_e s);
    return (s == LS_UC) || (s == LS_UD);
  endfunction

  function automatic logic ls_dirty(lstate_e s);
    return (s == LS_UD) || (s == LS_SD);
  endfunction

  function automatic lstate_e ls_share(lstate_e s);
    lstate_e r;
    case (s)
      LS_UC:   r = LS_SC;
      LS_UD:   r = LS_SD;
      default: r = s;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/coh_arb.sv
module coh_arb #(
  parameter int N = 2
) (
  input  logic         en_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  // lowest index wins
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    for (int i = 0; i < N; i++) begin
      if (en_i && req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/coh_dir.sv
module coh_dir
  import coh_pkg::*;
#(
  parameter int AW = 3,
  parameter int NC = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic    [NC-1:0]                upd_i,
  input  logic    [AW-1:0]                upd_addr_i,
  input  lstate_e [NC-1:0]                upd_st_i,
  input  logic    [AW-1:0]                rd_addr_i,
  output lstate_e [NC-1:0]                rd_st_o,
  output lstate_e [NC-1:0][(1<<AW)-1:0]   tab_o
);
  localparam int LINES = 1 << AW;

  lstate_e [NC-1:0][LINES-1:0] tab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < NC; c++)
        for (int l = 0; l < LINES; l++)
          tab_q[c][l] <= LS_INV;
    end else begin
      for (int c = 0; c < NC; c++)
        if (upd_i[c]) tab_q[c][upd_addr_i] <= upd_st_i[c];
    end
  end

  always_comb begin
    for (int c = 0; c < NC; c++) rd_st_o[c] = tab_q[c][rd_addr_i];
  end

  assign tab_o = tab_q;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    for (genvar c = 0; c < NC; c++) begin : g_cl
      logic peer_valid;
      always_comb begin
        peer_valid = 1'b0;
        for (int d = 0; d < NC; d++)
          if (d != c && tab_q[d][l] != LS_INV) peer_valid = 1'b1;
      end
      a_r11_unique_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ls_uniq(tab_q[c][l]) |-> !peer_valid);
    end
  end
endmodule

// File: rtl/coh_eng.sv
module coh_eng
  import coh_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             gnt_i,
  output logic                   idle_o,
  input  logic [1:0][1:0]        req_op_i,
  input  logic [1:0][AW-1:0]     req_addr_i,
  output logic [AW-1:0]          dir_addr_o,
  input  lstate_e [1:0]          dir_st_i,
  output logic [1:0]             upd_o,
  output lstate_e [1:0]          upd_st_o,
  output logic [1:0]             rsp_valid_o,
  output logic                   rsp_ok_o,
  output lstate_e                rsp_st_o,
  output logic [DW-1:0]          rsp_data_o,
  output logic [1:0]             snp_valid_o,
  output logic                   snp_inv_o,
  output logic [AW-1:0]          snp_addr_o,
  input  logic [1:0]             snp_rsp_valid_i,
  input  logic [1:0]             snp_rsp_hit_i,
  input  logic [1:0][DW-1:0]     snp_rsp_data_i,
  output logic                   mem_req_o,
  output logic [AW-1:0]          mem_addr_o,
  input  logic                   mem_rsp_valid_i,
  input  logic [DW-1:0]          mem_rsp_data_i
);
  eng_e          st_q, st_d;
  logic          src_q, src_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          inv_q, inv_d;
  logic          cur, peer;
  lstate_e       own, oth, merged;
  op_e           op_in;
  logic          rsp_fire, ok_d, snp_fire, mem_fire;
  lstate_e       rst_d;
  logic [DW-1:0] data_d;

  logic [1:0]    rsp_valid_q, snp_valid_q;
  logic          rsp_ok_q, snp_inv_q, mem_req_q;
  lstate_e       rsp_st_q;
  logic [DW-1:0] rsp_data_q;

  assign idle_o     = (st_q == EG_IDLE);
  assign cur        = idle_o ? gnt_i[1] : src_q;
  assign peer       = ~cur;
  assign dir_addr_o = idle_o ? req_addr_i[gnt_i[1]] : addr_q;
  assign own        = dir_st_i[cur];
  assign oth        = dir_st_i[peer];
  assign op_in      = op_e'(req_op_i[cur]);
  assign merged     = (ls_dirty(own) || ls_dirty(oth)) ? LS_UD : LS_UC;

  always_comb begin
    st_d     = st_q;
    src_d    = src_q;
    addr_d   = addr_q;
    inv_d    = inv_q;
    upd_o    = '0;
    upd_st_o = dir_st_i;
    rsp_fire = 1'b0;
    ok_d     = 1'b0;
    rst_d    = own;
    data_d   = '0;
    snp_fire = 1'b0;
    mem_fire = 1'b0;
    case (st_q)
      EG_IDLE: begin
        if (|gnt_i) begin
          src_d  = cur;
          addr_d = dir_addr_o;
          case (op_in)
            OP_RD: begin
              if (ls_valid(own)) begin
                rsp_fire = 1'b1;
                ok_d     = 1'b1;
              end else begin
                st_d     = EG_SNP;
                inv_d    = 1'b0;
                snp_fire = 1'b1;
              end
            end
            OP_MU: begin
              if (ls_uniq(own)) begin
                rsp_fire = 1'b1;
                ok_d     = 1'b1;
              end else if (ls_valid(own)) begin
                st_d     = EG_SNP;
                inv_d    = 1'b1;
                snp_fire = 1'b1;
              end else begin
                rsp_fire = 1'b1;
              end
            end
            OP_ST: begin
              rsp_fire = 1'b1;
              if (ls_uniq(own)) begin
                ok_d           = 1'b1;
                rst_d          = LS_UD;
                upd_o[cur]     = 1'b1;
                upd_st_o[cur]  = LS_UD;
              end
            end
            default: rsp_fire = 1'b1;
          endcase
        end
      end
      EG_SNP: begin
        if (snp_rsp_valid_i[peer]) begin
          if (inv_q) begin
            // acknowledge of invalidate: requester takes ownership
            upd_o          = 2'b11;
            upd_st_o[cur]  = merged;
            upd_st_o[peer] = LS_INV;
            rsp_fire       = 1'b1;
            ok_d           = 1'b1;
            rst_d          = merged;
            st_d           = EG_IDLE;
          end else if (snp_rsp_hit_i[peer]) begin
            upd_o          = 2'b11;
            upd_st_o[cur]  = LS_SC;
            upd_st_o[peer] = ls_share(oth);
            rsp_fire       = 1'b1;
            ok_d           = 1'b1;
            rst_d          = LS_SC;
            data_d         = snp_rsp_data_i[peer];
            st_d           = EG_IDLE;
          end else begin
            mem_fire = 1'b1;
            st_d     = EG_MEM;
          end
        end
      end
      EG_MEM: begin
        if (mem_rsp_valid_i) begin
          upd_o[cur]    = 1'b1;
          upd_st_o[cur] = LS_UC;
          rsp_fire      = 1'b1;
          ok_d          = 1'b1;
          rst_d         = LS_UC;
          data_d        = mem_rsp_data_i;
          st_d          = EG_IDLE;
        end
      end
      default: st_d = EG_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= EG_IDLE;
      src_q       <= 1'b0;
      addr_q      <= '0;
      inv_q       <= 1'b0;
      rsp_valid_q <= '0;
      rsp_ok_q    <= 1'b0;
      rsp_st_q    <= LS_INV;
      rsp_data_q  <= '0;
      snp_valid_q <= '0;
      snp_inv_q   <= 1'b0;
      mem_req_q   <= 1'b0;
    end else begin
      st_q        <= st_d;
      src_q       <= src_d;
      addr_q      <= addr_d;
      inv_q       <= inv_d;
      rsp_valid_q <= '0;
      snp_valid_q <= '0;
      mem_req_q   <= mem_fire;
      if (rsp_fire) begin
        rsp_valid_q[cur] <= 1'b1;
        rsp_ok_q         <= ok_d;
        rsp_st_q         <= rst_d;
        rsp_data_q       <= data_d;
      end
      if (snp_fire) begin
        snp_valid_q[peer] <= 1'b1;
        snp_inv_q         <= inv_d;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_ok_o    = rsp_ok_q;
  assign rsp_st_o    = rsp_st_q;
  assign rsp_data_o  = rsp_data_q;
  assign snp_valid_o = snp_valid_q;
  assign snp_inv_o   = snp_inv_q;
  assign snp_addr_o  = addr_q;
  assign mem_req_o   = mem_req_q;
  assign mem_addr_o  = addr_q;

  a_r2_one_snoop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(snp_valid_o));

  a_r3_mem_after_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> $past(|(snp_rsp_valid_i & ~snp_rsp_hit_i)));

  a_r4_hit_grants_shared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == EG_SNP && !inv_q && snp_rsp_valid_i[~src_q] && snp_rsp_hit_i[~src_q])
      |=> (rsp_valid_o[src_q] && rsp_st_o == LS_SC));
endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
  import coh_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [1:0]                    req_valid_i,
  input  logic [1:0][1:0]               req_op_i,
  input  logic [1:0][AW-1:0]            req_addr_i,
  output logic [1:0]                    req_ready_o,
  output logic [1:0]                    rsp_valid_o,
  output logic                          rsp_ok_o,
  output logic [2:0]                    rsp_state_o,
  output logic [DW-1:0]                 rsp_data_o,
  output logic [1:0]                    snp_valid_o,
  output logic                          snp_inv_o,
  output logic [AW-1:0]                 snp_addr_o,
  input  logic [1:0]                    snp_rsp_valid_i,
  input  logic [1:0]                    snp_rsp_hit_i,
  input  logic [1:0][DW-1:0]            snp_rsp_data_i,
  output logic                          mem_req_o,
  output logic [AW-1:0]                 mem_addr_o,
  input  logic                          mem_rsp_valid_i,
  input  logic [DW-1:0]                 mem_rsp_data_i,
  output logic [1:0][(1<<AW)-1:0][2:0]  dbg_state_o
);
  localparam int NC    = 2;
  localparam int LINES = 1 << AW;

  logic                        idle;
  logic [NC-1:0]               gnt;
  logic [AW-1:0]               dir_addr;
  lstate_e [NC-1:0]            dir_st;
  logic [NC-1:0]               upd;
  lstate_e [NC-1:0]            upd_st;
  lstate_e                     rsp_st;
  lstate_e [NC-1:0][LINES-1:0] tab;

  coh_arb #(.N(NC)) u_arb (
    .en_i  (idle),
    .req_i (req_valid_i),
    .gnt_o (gnt)
  );

  coh_dir #(.AW(AW), .NC(NC)) u_dir (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_i      (upd),
    .upd_addr_i (dir_addr),
    .upd_st_i   (upd_st),
    .rd_addr_i  (dir_addr),
    .rd_st_o    (dir_st),
    .tab_o      (tab)
  );

  coh_eng #(.AW(AW), .DW(DW)) u_eng (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .gnt_i           (gnt),
    .idle_o          (idle),
    .req_op_i        (req_op_i),
    .req_addr_i      (req_addr_i),
    .dir_addr_o      (dir_addr),
    .dir_st_i        (dir_st),
    .upd_o           (upd),
    .upd_st_o        (upd_st),
    .rsp_valid_o     (rsp_valid_o),
    .rsp_ok_o        (rsp_ok_o),
    .rsp_st_o        (rsp_st),
    .rsp_data_o      (rsp_data_o),
    .snp_valid_o     (snp_valid_o),
    .snp_inv_o       (snp_inv_o),
    .snp_addr_o      (snp_addr_o),
    .snp_rsp_valid_i (snp_rsp_valid_i),
    .snp_rsp_hit_i   (snp_rsp_hit_i),
    .snp_rsp_data_i  (snp_rsp_data_i),
    .mem_req_o       (mem_req_o),
    .mem_addr_o      (mem_addr_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_data_i  (mem_rsp_data_i)
  );

  assign req_ready_o = gnt;
  assign rsp_state_o = rsp_st;
  assign dbg_state_o = tab;

  a_r9_single_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_ready_o));

  a_r9_ready_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o & ~req_valid_i) == '0);

  // snp_addr_o holds the address of the transaction being answered
  for (genvar c = 0; c < NC; c++) begin : g_excl
    a_r5_grant_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rsp_valid_o[c] && rsp_ok_o && (rsp_st == LS_UC || rsp_st == LS_UD))
        |-> (tab[1-c][snp_addr_o] == LS_INV));
  end
endmodule

// File: tb/coh_ctrl_bench.sv
`timescale 1ns/1ps
module coh_ctrl_bench;
  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       req_valid;
  logic [1:0][1:0]  req_op;
  logic [1:0][2:0]  req_addr;
  logic [1:0]       req_ready_o, rsp_valid_o, snp_valid_o;
  logic             rsp_ok_o, snp_inv_o, mem_req_o;
  logic [2:0]       rsp_state_o, snp_addr_o, mem_addr_o;
  logic [31:0]      rsp_data_o;
  logic [1:0]       snp_rsp_valid, snp_rsp_hit;
  logic [1:0][31:0] snp_rsp_data;
  logic             mem_rsp_valid;
  logic [31:0]      mem_rsp_data;
  logic [1:0][7:0][2:0] dbg_state_o;

  int total = 0;
  int bad = 0;
  int exp_st[2][8];
  int snp_tot = 0;
  int mem_tot = 0;
  int last_c, last_inv, last_addr;
  int inv_bad = 0;

  always #5 clk = ~clk;

  coh_ctrl u_coh_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_addr_i(req_addr),
    .req_ready_o(req_ready_o),
    .rsp_valid_o(rsp_valid_o), .rsp_ok_o(rsp_ok_o), .rsp_state_o(rsp_state_o),
    .rsp_data_o(rsp_data_o),
    .snp_valid_o(snp_valid_o), .snp_inv_o(snp_inv_o), .snp_addr_o(snp_addr_o),
    .snp_rsp_valid_i(snp_rsp_valid), .snp_rsp_hit_i(snp_rsp_hit),
    .snp_rsp_data_i(snp_rsp_data),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_data_i(mem_rsp_data),
    .dbg_state_o(dbg_state_o)
  );

  // cluster and memory models: miss 6, outer hit 13, inner hit 16 (odd lines), memory 4
  initial begin
    int scnt[2];
    int shit[2];
    int saddr[2];
    int mcnt;
    int maddr;
    scnt = '{0, 0}; shit = '{0, 0}; saddr = '{0, 0}; mcnt = 0; maddr = 0;
    snp_rsp_valid = '0; snp_rsp_hit = '0; snp_rsp_data = '0;
    mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      for (int c = 0; c < 2; c++) begin
        snp_rsp_valid[c] = 1'b0; snp_rsp_hit[c] = 1'b0; snp_rsp_data[c] = '0;
        if (scnt[c] > 0) begin
          scnt[c]--;
          if (scnt[c] == 0) begin
            snp_rsp_valid[c] = 1'b1;
            snp_rsp_hit[c]   = (shit[c] != 0);
            snp_rsp_data[c]  = 32'hC000_0000 + 32'(c * 256) + 32'(saddr[c]);
          end
        end
        if (snp_valid_o[c]) begin
          snp_tot++;
          last_c = c; last_inv = int'(snp_inv_o); last_addr = int'(snp_addr_o);
          saddr[c] = int'(snp_addr_o);
          shit[c]  = (exp_st[c][snp_addr_o] != 0) ? 1 : 0;
          scnt[c]  = (shit[c] == 0) ? 6 : (snp_addr_o[0] ? 16 : 13);
        end
      end
      mem_rsp_valid = 1'b0; mem_rsp_data = '0;
      if (mcnt > 0) begin
        mcnt--;
        if (mcnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = 32'hA000_0000 + 32'(maddr);
        end
      end
      if (mem_req_o) begin
        mem_tot++;
        maddr = int'(mem_addr_o);
        mcnt  = 4;
      end
    end
  end

  // R11 monitor on the debug port
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 8; a++)
          if ((dbg_state_o[c][a] == 3'd1 || dbg_state_o[c][a] == 3'd3) && dbg_state_o[1-c][a] != 3'd0)
            inv_bad++;
    end
  end

  task automatic chk_eq(input string rq, input string what, input longint act, input longint expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
    end
  endtask

  task automatic chk_dbg(input string rq);
    int mism;
    mism = 0;
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 8; a++)
        if (int'(dbg_state_o[c][a]) != exp_st[c][a]) begin
          if (mism == 0)
            $display("FAIL %s table c%0d line%0d actual=%0d expected=%0d", rq, c, a,
                     dbg_state_o[c][a], exp_st[c][a]);
          mism++;
        end
    total++;
    if (mism != 0) bad++;
  endtask

  task automatic do_req(input int c, input int op, input int a, input int eok, input int est,
                        input int elat, input int esnp, input int emem, input int chkd,
                        input logic [31:0] ed, input string rq);
    int n, s0, m0;
    s0 = snp_tot; m0 = mem_tot;
    @(negedge clk);
    req_valid[c] = 1'b1; req_op[c] = 2'(op); req_addr[c] = 3'(a);
    #1;
    while (!req_ready_o[c]) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid[c] = 1'b0;
    n = 1;
    while (!rsp_valid_o[c] && n < 1000) begin @(negedge clk); n++; end
    chk_eq(rq, "rsp_ok", rsp_ok_o, eok);
    chk_eq(rq, "rsp_state", rsp_state_o, est);
    chk_eq(rq, "latency", n, elat);
    if (chkd != 0) chk_eq(rq, "rsp_data", rsp_data_o, ed);
    chk_eq(rq, "snoops", snp_tot - s0, esnp);
    chk_eq(rq, "mem reads", mem_tot - m0, emem);
  endtask

  task automatic arb_case();
    int n, stall_bad;
    @(negedge clk);
    req_valid = 2'b11; req_op[0] = 2'd0; req_op[1] = 2'd0; req_addr[0] = 3'd6; req_addr[1] = 3'd6;
    #1;
    chk_eq("R9", "tie grant", req_ready_o, 2'b01);
    @(negedge clk);
    req_valid[0] = 1'b0;
    #1;
    n = 0; stall_bad = 0;
    while (!rsp_valid_o[0] && n < 1000) begin
      if (req_ready_o[1]) stall_bad++;
      @(negedge clk); #1; n++;
    end
    chk_eq("R9", "stalled accept", stall_bad, 0);
    chk_eq("R9", "winner state", rsp_state_o, 1);
    exp_st[0][6] = 1;
    chk_eq("R9", "loser accepted after response", req_ready_o[1], 1);
    @(negedge clk);
    req_valid[1] = 1'b0;
    n = 0;
    while (!rsp_valid_o[1] && n < 1000) begin @(negedge clk); n++; end
    chk_eq("R9", "loser state", rsp_state_o, 2);
    chk_eq("R9", "loser data", rsp_data_o, 32'hC000_0006);
    exp_st[0][6] = 2; exp_st[1][6] = 2;
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) for (int a = 0; a < 8; a++) exp_st[c][a] = 0;
    rst_n = 1'b0; req_valid = '0; req_op = '0; req_addr = '0;
    repeat (3) @(negedge clk);
    chk_dbg("R1");
    chk_eq("R1", "rsp_valid", rsp_valid_o, 0);
    chk_eq("R1", "snp_valid", snp_valid_o, 0);
    chk_eq("R1", "mem_req", mem_req_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3: read miss fills from memory
    do_req(0, 0, 2, 1, 1, 13, 1, 1, 1, 32'hA000_0002, "R3");
    chk_eq("R2", "snoop target", last_c, 1);
    chk_eq("R2", "snoop kind", last_inv, 0);
    chk_eq("R2", "snoop addr", last_addr, 2);
    exp_st[0][2] = 1;
    // R8: local hit
    do_req(0, 0, 2, 1, 1, 1, 0, 0, 0, '0, "R8");
    // R7: store on unique
    do_req(0, 2, 2, 1, 3, 1, 0, 0, 0, '0, "R7");
    exp_st[0][2] = 3;
    chk_dbg("R7");
    // R4 R10: snoop hit on dirty holder, outer latency 13
    do_req(1, 0, 2, 1, 2, 15, 1, 0, 1, 32'hC000_0002, "R4");
    exp_st[1][2] = 2; exp_st[0][2] = 4;
    chk_dbg("R4");
    // R7: store on shared is refused
    do_req(1, 2, 2, 0, 2, 1, 0, 0, 0, '0, "R7");
    chk_dbg("R7");
    // R5: make-unique, dirty copy elsewhere
    do_req(1, 1, 2, 1, 3, 15, 1, 0, 0, '0, "R5");
    chk_eq("R5", "inval target", last_c, 0);
    chk_eq("R5", "inval kind", last_inv, 1);
    exp_st[1][2] = 3; exp_st[0][2] = 0;
    chk_dbg("R5");
    // R6: make-unique on invalid and on unique
    do_req(0, 1, 3, 0, 0, 1, 0, 0, 0, '0, "R6");
    do_req(1, 1, 2, 1, 3, 1, 0, 0, 0, '0, "R6");
    chk_dbg("R6");
    // R10: inner latency 16 on odd line
    do_req(0, 0, 5, 1, 1, 13, 1, 1, 1, 32'hA000_0005, "R10");
    exp_st[0][5] = 1;
    do_req(1, 0, 5, 1, 2, 18, 1, 0, 1, 32'hC000_0005, "R10");
    exp_st[1][5] = 2; exp_st[0][5] = 2;
    do_req(0, 1, 5, 1, 1, 18, 1, 0, 0, '0, "R5");
    exp_st[0][5] = 1; exp_st[1][5] = 0;
    chk_dbg("R5");
    // R9: simultaneous requests
    arb_case();
    chk_dbg("R9");
    chk_eq("R11", "exclusivity violations", inv_bad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule